// File: doc/BRIEF.md
# Full-Duplex Serial Master with Slave-Ready Gating

This block is the serial master side of a host processor's peripheral port. Software places a 24-bit word in a single-entry transmit holding register. That write is all it takes to start an exchange. The word moves into an internal shift register, and the block produces a burst of serial clock pulses from the system clock through a programmable divider. It sends the word out most-significant bit first on MOSI and at the same time captures the same number of bits from MISO. Each received word is pushed into a two-entry receive queue that software drains one word at a time.

Clock polarity and phase are selectable. A 2-bit request-enable field can make every burst wait for a slave-driven ready line. The master samples that line only when a word is about to begin, through a two-stage synchronizer. The slave releases the line at the first clock edge of the word. The burst then always runs to completion, and the next word stays parked until ready comes back. The master's own select input must stay high. If it is driven low, a sticky bus-error flag is set, and an interrupt request follows when the error interrupt is enabled. Dropping the enable input clears the whole block, including the receive queue.

Top module: `spi_hs_master`

## Requirements
- R1: After reset with `enable` high, `tx_empty` is 1, `rx_not_empty`, `rx_overrun`, `bus_err` and `irq` are 0, and `sck` equals `cpol`.
- R2: A write accepted while `tx_empty` is 1 starts a full-duplex transfer of 24 bits. MOSI carries the written word MSB first. The 24 bits sampled from MISO, first bit as MSB, form the word pushed into the receive queue.
- R3: With `cpha`=0, MISO is sampled on the leading (odd-numbered) clock edges and MOSI changes on the trailing edges. With `cpha`=1, MOSI changes on leading edges and MISO is sampled on trailing edges. Between words `sck` rests at `cpol`.
- R4: Each word produces exactly 48 `sck` transitions, and consecutive transitions are `clk_div`+1 system clocks apart.
- R5: `tx_empty` drops to 0 in the cycle after a write is accepted. It returns to 1 when the held word moves into the shifter. A write made while `tx_empty` is 0 is ignored.
- R6: The receive queue holds 2 words in arrival order. `rx_data` shows the oldest word while `rx_not_empty` is 1, and a one-cycle `rx_rd` removes it.
- R7: A word that completes while the queue is full is discarded, and `rx_overrun` is set and stays set.
- R8: With `req_en`=00, `slave_rdy` is ignored and a held word starts as soon as the shifter is idle.
- R9: With `req_en`≠00, a held word starts only while the synchronized `slave_rdy` is 1. A started word runs all 48 edges even if ready falls. The next word waits with no `sck` activity until ready is 1 again.
- R10: `ss_in_n` low while enabled sets `bus_err` within 4 clock cycles, and `bus_err` stays set after `ss_in_n` returns high.
- R11: `irq` is 1 exactly when `bus_err` and `err_ie` are both 1.
- R12: With `enable` low, the next clock clears the holding register, the receive queue, `rx_overrun` and `bus_err`, and stops any transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Interface enable; low clears the block |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Clock phase select |
| clk_div | input | 4 | Half-period of `sck` minus one, in system clocks |
| req_en | input | 2 | Ready-gating enable; 00 ignores `slave_rdy` |
| err_ie | input | 1 | Bus-error interrupt enable |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_data | input | 24 | Word to transmit |
| rx_rd | input | 1 | Pop strobe for the receive queue |
| rx_data | output | 24 | Oldest received word |
| tx_empty | output | 1 | Holding register may be written |
| rx_not_empty | output | 1 | Receive queue holds a word |
| rx_overrun | output | 1 | Sticky: a word was lost to a full queue |
| bus_err | output | 1 | Sticky: own select input seen low |
| irq | output | 1 | Bus-error interrupt request |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_in_n | input | 1 | Master's own select input, must stay high |
| slave_rdy | input | 1 | Slave-ready handshake line |

## Verification
The bench sweeps every polarity and phase combination against three divider settings. It rebuilds each MOSI word from the clock edges it sees and measures every half period, so a design that samples or shifts on the wrong edge, or that miscounts edges, shows up as a corrupted word or a wrong interval. It holds ready low and expects total clock silence, then lets the slave drop ready on the first edge and expects the burst to finish anyway. A design that re-checks ready mid-word would truncate the word, and one that ignores the gate would clock early. It also overfills the two-entry queue and writes into a full holding register: a design that overwrote either would return the wrong word order or lose the overrun flag. The remaining scenarios cover the sticky bus error and its interrupt, and the clearing effect of the enable input.

// File: rtl/spi_hs_pkg.sv
package spi_hs_pkg;

  typedef enum logic {
    ENG_IDLE = 1'b0,
    ENG_RUN  = 1'b1
  } eng_state_e;

  // An sck transition is leading when its index within the word is even.
  function automatic logic edge_is_leading(input logic edge_idx_lsb);
    return ~edge_idx_lsb;
  endfunction

  // Sample on leading edges for phase 0, trailing edges for phase 1.
  function automatic logic edge_samples(input logic phase_sel, input logic leading);
    return phase_sel ? ~leading : leading;
  endfunction

endpackage

// File: rtl/spi_hs_rxfifo.sv
module spi_hs_rxfifo #(
  parameter int unsigned W     = 24,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         not_empty,
  output logic         full,
  output logic         ovr
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  logic [W-1:0]     slot_q [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [CNT_W-1:0] count;
  logic             push_ok, pop_ok, push_lost;

  assign full      = (count == CNT_W'(DEPTH));
  assign not_empty = (count != '0);
  assign push_ok   = push & ~full;
  assign pop_ok    = pop & not_empty;
  assign push_lost = push & full;
  assign head      = slot_q[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
      ovr    <= 1'b0;
    end else if (clr) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
      ovr    <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= ptr_inc(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_inc(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
      if (push_lost) ovr <= 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[g] <= '0;
      else if (push_ok && wr_ptr == PTR_W'(g)) slot_q[g] <= push_data;
    end
  end

  // R6
  fifo_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R7
  fifo_overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_lost && !clr) |=> ovr);

  // R7
  fifo_lost_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_lost && !pop && !clr) |=> full);

endmodule

// File: rtl/spi_hs_shifter.sv
module spi_hs_shifter
  import spi_hs_pkg::*;
#(
  parameter int unsigned W     = 24,
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             cpol,
  input  logic             cpha,
  input  logic [DIV_W-1:0] div,
  input  logic             start,
  input  logic [W-1:0]     tx_word,
  input  logic             miso,
  output logic             busy,
  output logic             sck,
  output logic             mosi,
  output logic             done,
  output logic [W-1:0]     rx_word
);
  localparam int unsigned EDGES     = 2 * W;
  localparam int unsigned EDGE_W    = $clog2(EDGES);
  localparam int unsigned EDGE_LAST = EDGES - 1;

  eng_state_e        state;
  logic [DIV_W-1:0]  div_cnt;
  logic [EDGE_W-1:0] edge_cnt;
  logic              phase_q;
  logic [W-1:0]      tx_sr, rx_sr;

  // named internal events
  logic tick_ev, lead_ev, sample_ev, shift_ev, last_ev;

  assign tick_ev   = (state == ENG_RUN) && (div_cnt >= div);
  assign lead_ev   = tick_ev && edge_is_leading(edge_cnt[0]);
  assign sample_ev = tick_ev && edge_samples(cpha, lead_ev);
  assign shift_ev  = tick_ev && !sample_ev && !(cpha && edge_cnt == '0);
  assign last_ev   = tick_ev && (edge_cnt == EDGE_W'(EDGE_LAST));

  assign busy    = (state == ENG_RUN);
  assign sck     = cpol ^ phase_q;
  assign mosi    = tx_sr[W-1];
  assign rx_word = rx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ENG_IDLE;
      div_cnt  <= '0;
      edge_cnt <= '0;
      phase_q  <= 1'b0;
      tx_sr    <= '0;
      rx_sr    <= '0;
      done     <= 1'b0;
    end else if (clr) begin
      state    <= ENG_IDLE;
      div_cnt  <= '0;
      edge_cnt <= '0;
      phase_q  <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == ENG_IDLE) begin
        if (start) begin
          tx_sr    <= tx_word;
          div_cnt  <= '0;
          edge_cnt <= '0;
          state    <= ENG_RUN;
        end
      end else if (tick_ev) begin
        div_cnt  <= '0;
        phase_q  <= ~phase_q;
        edge_cnt <= edge_cnt + EDGE_W'(1);
        if (sample_ev) rx_sr <= {rx_sr[W-2:0], miso};
        if (shift_ev)  tx_sr <= {tx_sr[W-2:0], 1'b0};
        if (last_ev) begin
          state    <= ENG_IDLE;
          edge_cnt <= '0;
          done     <= 1'b1;
        end
      end else begin
        div_cnt <= div_cnt + DIV_W'(1);
      end
    end
  end

  // R3
  eng_idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck == cpol));

  // R2
  eng_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);

  // R4
  eng_done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (edge_cnt == '0) && !phase_q);

endmodule

// File: rtl/spi_hs_master.sv
module spi_hs_master #(
  parameter int unsigned W          = 24,
  parameter int unsigned DIV_W      = 4,
  parameter int unsigned FIFO_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             cpol,
  input  logic             cpha,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [1:0]       req_en,
  input  logic             err_ie,
  input  logic             tx_wr,
  input  logic [W-1:0]     tx_data,
  input  logic             rx_rd,
  output logic [W-1:0]     rx_data,
  output logic             tx_empty,
  output logic             rx_not_empty,
  output logic             rx_overrun,
  output logic             bus_err,
  output logic             irq,
  output logic             sck,
  output logic             mosi,
  input  logic             miso,
  input  logic             ss_in_n,
  input  logic             slave_rdy
);
  logic         clr;
  logic         rdy_s1, rdy_s2, ss_s1, ss_s2;
  logic [W-1:0] hold_q;
  logic         hold_full;
  logic         wr_accept, ready_ok, start_ev;
  logic         eng_busy, eng_done;
  logic [W-1:0] eng_rx;
  logic         fifo_full;

  assign clr       = ~enable;
  assign wr_accept = enable && tx_wr && !hold_full;
  assign ready_ok  = (req_en == 2'b00) || rdy_s2;
  assign start_ev  = enable && hold_full && !eng_busy && ready_ok;
  assign tx_empty  = ~hold_full;
  assign irq       = bus_err & err_ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_s1 <= 1'b0;
      rdy_s2 <= 1'b0;
      ss_s1  <= 1'b1;
      ss_s2  <= 1'b1;
    end else begin
      rdy_s1 <= slave_rdy;
      rdy_s2 <= rdy_s1;
      ss_s1  <= ss_in_n;
      ss_s2  <= ss_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
      bus_err   <= 1'b0;
    end else if (clr) begin
      hold_full <= 1'b0;
      bus_err   <= 1'b0;
    end else begin
      if (wr_accept) begin
        hold_q    <= tx_data;
        hold_full <= 1'b1;
      end else if (start_ev) begin
        hold_full <= 1'b0;
      end
      if (!ss_s2) bus_err <= 1'b1;
    end
  end

  spi_hs_shifter #(.W(W), .DIV_W(DIV_W)) eng_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .cpol    (cpol),
    .cpha    (cpha),
    .div     (clk_div),
    .start   (start_ev),
    .tx_word (hold_q),
    .miso    (miso),
    .busy    (eng_busy),
    .sck     (sck),
    .mosi    (mosi),
    .done    (eng_done),
    .rx_word (eng_rx)
  );

  spi_hs_rxfifo #(.W(W), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .push      (eng_done),
    .push_data (eng_rx),
    .pop       (rx_rd),
    .head      (rx_data),
    .not_empty (rx_not_empty),
    .full      (fifo_full),
    .ovr       (rx_overrun)
  );

  // R9
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev && req_en != 2'b00) |-> $past(slave_rdy, 2));

  // R5
  write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && tx_wr && !tx_empty && !start_ev) |=> !tx_empty);

  // R10
  bus_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && enable) |=> bus_err);

  // R12
  disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (tx_empty && !rx_not_empty && !rx_overrun && !bus_err && !eng_busy));

endmodule

// File: tb/spi_hs_master_tb.sv
module spi_hs_master_tb_top;
  localparam int CLK_P = 10;
  localparam int WB    = 24;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b1, cpol = 1'b0, cpha = 1'b0;
  logic [3:0] clk_div = 4'd0;
  logic [1:0] req_en = 2'b00;
  logic err_ie = 1'b0, tx_wr = 1'b0, rx_rd = 1'b0;
  logic [WB-1:0] tx_data = '0, rx_data;
  logic tx_empty, rx_not_empty, rx_overrun, bus_err, irq, sck, mosi, miso;
  logic ss_in_n = 1'b1, slave_rdy = 1'b0, loop_en = 1'b1, miso_lvl = 1'b0;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;
  assign miso = loop_en ? mosi : miso_lvl;

  spi_hs_master dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cpol(cpol), .cpha(cpha),
    .clk_div(clk_div), .req_en(req_en), .err_ie(err_ie), .tx_wr(tx_wr),
    .tx_data(tx_data), .rx_rd(rx_rd), .rx_data(rx_data), .tx_empty(tx_empty),
    .rx_not_empty(rx_not_empty), .rx_overrun(rx_overrun), .bus_err(bus_err),
    .irq(irq), .sck(sck), .mosi(mosi), .miso(miso), .ss_in_n(ss_in_n),
    .slave_rdy(slave_rdy)
  );

  // Line monitor: counts sck transitions, measures spacing, rebuilds MOSI.
  logic sck_prev = 1'b0;
  int edges = 0, hp_cnt = 0, hp_min = 1000, hp_max = 0;
  logic [WB-1:0] mon_word = '0;

  always @(negedge clk) begin
    hp_cnt++;
    if (sck !== sck_prev) begin
      if ((cpha == 1'b0) == (edges % 2 == 0)) mon_word = {mon_word[WB-2:0], mosi};
      if (edges > 0) begin
        if (hp_cnt < hp_min) hp_min = hp_cnt;
        if (hp_cnt > hp_max) hp_max = hp_cnt;
      end
      hp_cnt = 0;
      edges++;
    end
    sck_prev = sck;
  end

  task automatic mon_reset();
    edges = 0; hp_cnt = 0; hp_min = 1000; hp_max = 0; mon_word = '0; sck_prev = sck;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_edges(int n);
    while (edges < n) @(negedge clk);
  endtask

  task automatic write_word(logic [WB-1:0] w);
    while (!tx_empty) @(negedge clk);
    tx_data = w; tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic pop_word();
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
  endtask

  task automatic pulse_disable();
    enable = 1'b0;
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    logic [WB-1:0] w, w1, w2, w3;
    int idx;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 tx_empty", tx_empty, 1);
    chk("R1 rx_not_empty", rx_not_empty, 0);
    chk("R1 rx_overrun", rx_overrun, 0);
    chk("R1 bus_err", bus_err, 0);
    chk("R1 irq", irq, 0);
    chk("R1 sck idle", sck, cpol);

    // R2 R3 R4 sweep: every mode against three divider values, loopback
    idx = 0;
    for (int m = 0; m < 4; m++) begin
      for (int d = 0; d < 3; d++) begin
        cpol = m[1]; cpha = m[0];
        clk_div = (d == 0) ? 4'd0 : (d == 1) ? 4'd1 : 4'd3;
        repeat (2) @(negedge clk);
        mon_reset();
        w = WB'(24'hA50F3C ^ (idx * 24'h13579B));
        idx++;
        write_word(w);
        wait_edges(48);
        repeat (4) @(negedge clk);
        chk("R2 mosi word", mon_word, w);
        chk("R4 edge count", edges, 48);
        chk("R4 half period min", hp_min, clk_div + 1);
        chk("R4 half period max", hp_max, clk_div + 1);
        chk("R3 idle level", sck, cpol);
        chk("R6 rx_not_empty", rx_not_empty, 1);
        chk("R3 loopback word", rx_data, w);
        pop_word();
        chk("R6 empty after pop", rx_not_empty, 0);
      end
    end

    // R2: constant MISO high while sending zeros
    cpol = 0; cpha = 1; clk_div = 0; loop_en = 0; miso_lvl = 1;
    repeat (2) @(negedge clk);
    mon_reset();
    write_word('0);
    wait_edges(48);
    repeat (4) @(negedge clk);
    chk("R2 mosi zeros", mon_word, 0);
    chk("R2 miso ones", rx_data, 24'hFFFFFF);
    pop_word();
    loop_en = 1;

    // R5 holding register timing and ignored write; R6 order
    cpha = 0;
    repeat (2) @(negedge clk);
    mon_reset();
    w1 = 24'h123456; w2 = 24'hABCDEF; w3 = 24'h0F0F0F;
    tx_data = w1; tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
    chk("R5 empty drops", tx_empty, 0);
    @(negedge clk);
    chk("R5 empty returns", tx_empty, 1);
    tx_data = w2; tx_wr = 1'b1;
    @(negedge clk);
    chk("R5 held while busy", tx_empty, 0);
    tx_data = w3;
    @(negedge clk);
    tx_wr = 1'b0;
    wait_edges(96);
    repeat (6) @(negedge clk);
    chk("R5 no third burst", edges, 96);
    chk("R6 first word", rx_data, w1);
    pop_word();
    chk("R6 second word", rx_data, w2);
    pop_word();
    chk("R6 drained", rx_not_empty, 0);
    chk("R7 no overrun", rx_overrun, 0);

    // R7 overrun: three words, no reads
    mon_reset();
    write_word(24'h111111);
    write_word(24'h222222);
    wait_edges(48);
    write_word(24'h333333);
    wait_edges(144);
    repeat (4) @(negedge clk);
    chk("R7 overrun set", rx_overrun, 1);
    chk("R7 oldest kept", rx_data, 24'h111111);
    pop_word();
    chk("R7 second kept", rx_data, 24'h222222);
    pop_word();
    chk("R7 third discarded", rx_not_empty, 0);
    chk("R7 overrun sticky", rx_overrun, 1);
    pulse_disable();
    chk("R12 overrun cleared", rx_overrun, 0);

    // R8 ready ignored when req_en is 00
    req_en = 2'b00; slave_rdy = 0;
    mon_reset();
    write_word(24'h5A5A5A);
    wait_edges(48);
    repeat (4) @(negedge clk);
    chk("R8 ran without ready", rx_data, 24'h5A5A5A);
    pop_word();

    // R9 ready-gated handshake, phase 1
    req_en = 2'b10; cpha = 1; slave_rdy = 0;
    repeat (2) @(negedge clk);
    mon_reset();
    write_word(24'hC0FFEE);
    repeat (40) @(negedge clk);
    chk("R9 no clocks without ready", edges, 0);
    chk("R9 word still held", tx_empty, 0);
    slave_rdy = 1;
    wait_edges(1);
    slave_rdy = 0;
    write_word(24'h0BEEF0);
    wait_edges(48);
    repeat (40) @(negedge clk);
    chk("R9 first word completed", edges, 48);
    chk("R9 next word parked", tx_empty, 0);
    chk("R9 first word received", rx_data, 24'hC0FFEE);
    req_en = 2'b01;
    slave_rdy = 1;
    wait_edges(49);
    slave_rdy = 0;
    wait_edges(96);
    repeat (4) @(negedge clk);
    chk("R9 second word mosi", mon_word, 24'h0BEEF0);
    pop_word();
    chk("R9 second word received", rx_data, 24'h0BEEF0);
    pop_word();
    req_en = 2'b00;

    // R10 R11 bus error, R12 clearing
    write_word(24'h777777);
    wait_edges(144);
    repeat (4) @(negedge clk);
    err_ie = 0; ss_in_n = 0;
    repeat (4) @(negedge clk);
    chk("R10 bus_err set", bus_err, 1);
    chk("R11 irq masked", irq, 0);
    ss_in_n = 1;
    repeat (4) @(negedge clk);
    chk("R10 bus_err sticky", bus_err, 1);
    err_ie = 1;
    #1;
    chk("R11 irq raised", irq, 1);
    chk("R12 fifo before clear", rx_not_empty, 1);
    pulse_disable();
    chk("R12 bus_err cleared", bus_err, 0);
    chk("R11 irq cleared", irq, 0);
    chk("R12 fifo cleared", rx_not_empty, 0);
    chk("R12 tx_empty", tx_empty, 1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule